// File: doc/BRIEF.md
# Post-Reset Alignment Read Enable Timer

After a synchronous trigger reset, this block holds back the read side of two groups of alignment FIFOs. It then releases each group after a programmed number of bunch-crossing clocks. The reset arrives as a one-cycle pulse. The late group is released a fixed base of 96 crossings plus a programmable delay after that pulse. The early group is released a second programmable offset sooner than the late group. The FIFOs themselves lie outside the block.

Delay and offset share one 16-bit host register that can be written and read back. Both fields have defined values after the block's reset. A value written to the register is captured only when a trigger reset pulse arrives, so a count that is already running is not disturbed. After the late threshold the counter stops, and both enables stay high until the next pulse.

Top module: `align_rd_timer`

## Requirements
- R1: After `rst_n` is released, `regRdData` reads 0x0070 (delay 112, offset 0), and both enables are low. Both enables stay low for any length of time until the first `l1Reset` pulse.
- R2: A write (`regWrEn` high at a clock edge) stores `regWrData[6:0]` as the delay D and `regWrData[11:8]` as the offset OFF. Bits 15:12 and 7 are ignored, and `regRdData` returns {4'b0, OFF, 1'b0, D} from the cycle after the write.
- R3: Let E0 be the clock edge at which `l1Reset` is sampled high. `lateRdEn` is low up to and including edge E0+95+D, and it is high after edge E0+96+D.
- R4: `earlyRdEn` goes high after edge E0+96+D−OFF and is low before that edge.
- R5: Once an enable is high, it stays high until the next `l1Reset` pulse. `earlyRdEn` is never low while `lateRdEn` is high.
- R6: An `l1Reset` pulse clears both enables at edge E0, even when they are high. A pulse that arrives during a count restarts the timing from that pulse.
- R7: D and OFF are captured at edge E0 from the register contents held before that edge. A write during a count does not change that count. A write in the same cycle as the pulse applies only from the following pulse.
- R8: After the late threshold the count does not wrap. With no further pulse, both enables stay high for at least 400 more cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| l1Reset | input | 1 | One-cycle synchronous trigger reset pulse |
| regWrEn | input | 1 | Host register write strobe |
| regWrData | input | 16 | Host register write data |
| regRdData | output | 16 | Host register read data |
| earlyRdEn | output | 1 | Read enable for the early FIFO group |
| lateRdEn | output | 1 | Read enable for the late FIFO group |

## Verification
The assertions assume that `l1Reset` and `regWrEn` are synchronous to `clk` and are stable around the rising edge. They also assume the base of 96 is at least the largest offset, so the early threshold cannot underflow. The bench changes every input only on the falling clock edge. It drives pulses that last exactly one cycle, and it keeps to the default base, so any pulse spacing and any register value it uses stay inside those assumptions. Pulses are spaced both far apart and in the middle of a count, and writes land during counts and in the same cycle as a pulse.

// File: rtl/align_timer_pkg.sv
package align_timer_pkg;

  typedef struct packed {
    logic restart;
    logic step;
  } tmrCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } tmrState_t;

endpackage

// File: rtl/align_cfg_reg.sv
module align_cfg_reg #(
  parameter int REG_W   = 16,
  parameter int DLY_W   = 7,
  parameter int OFF_W   = 4,
  parameter int OFF_LSB = 8,
  parameter int DLY_RST = 112,
  parameter int OFF_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic [DLY_W-1:0] dlyVal,
  output logic [OFF_W-1:0] offVal
);

  localparam int OFF_MSB = OFF_LSB + OFF_W - 1;
  localparam logic [REG_W-1:0] DLY_MASK = REG_W'((1 << DLY_W) - 1);
  localparam logic [REG_W-1:0] OFF_MASK = REG_W'(((1 << OFF_W) - 1) << OFF_LSB);
  localparam logic [REG_W-1:0] WR_MASK  = DLY_MASK | OFF_MASK;
  localparam logic [REG_W-1:0] RST_WORD =
    REG_W'(DLY_RST) | (REG_W'(OFF_RST) << OFF_LSB);

  logic [REG_W-1:0] cfgQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgQ <= RST_WORD;
    end else if (regWrEn) begin
      cfgQ <= regWrData & WR_MASK;
    end
  end

  assign regRdData = cfgQ;
  assign dlyVal    = cfgQ[DLY_W-1:0];
  assign offVal    = cfgQ[OFF_MSB:OFF_LSB];

  // R2: a write shows up, masked, on the read port one cycle later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> (regRdData == ($past(regWrData) & WR_MASK)));

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
  import align_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     l1Reset,
  input  logic     lateHit,
  output tmrCtrl_t ctrl
);

  tmrState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  stateD = ST_IDLE;
      ST_COUNT: if (lateHit) stateD = ST_HOLD;
      ST_HOLD:  stateD = ST_HOLD;
      default:  stateD = ST_IDLE;
    endcase
    if (l1Reset) stateD = ST_COUNT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    ctrl.restart = l1Reset;
    ctrl.step    = !l1Reset && (stateQ == ST_COUNT) && !lateHit;
  end

  // R6: every pulse puts the sequencer into counting
  a_r6_pulse_counts: assert property (@(posedge clk) disable iff (!rst_n)
    l1Reset |=> (stateQ == ST_COUNT));

  // R8: once the late threshold is reached the sequencer stops stepping
  a_r8_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_HOLD) |-> !ctrl.step);

endmodule

// File: rtl/align_dp.sv
module align_dp
  import align_timer_pkg::*;
#(
  parameter int BASE  = 96,
  parameter int DLY_W = 7,
  parameter int OFF_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrCtrl_t         ctrl,
  input  logic [DLY_W-1:0] dlyVal,
  input  logic [OFF_W-1:0] offVal,
  output logic             earlyRdEn,
  output logic             lateRdEn
);

  logic [CNT_W-1:0] cntQ, cntNext;
  logic [CNT_W-1:0] lateThrQ, earlyThrQ;
  logic [CNT_W-1:0] lateThrD, earlyThrD;
  logic             lateQ, earlyQ;

  always_comb begin
    lateThrD  = CNT_W'(BASE) + CNT_W'(dlyVal);
    earlyThrD = lateThrD - CNT_W'(offVal);
    cntNext   = cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ      <= '0;
      lateThrQ  <= '0;
      earlyThrQ <= '0;
      lateQ     <= 1'b0;
      earlyQ    <= 1'b0;
    end else if (ctrl.restart) begin
      cntQ      <= '0;
      lateThrQ  <= lateThrD;
      earlyThrQ <= earlyThrD;
      lateQ     <= 1'b0;
      earlyQ    <= 1'b0;
    end else if (ctrl.step) begin
      cntQ <= cntNext;
      if (cntNext == earlyThrQ) earlyQ <= 1'b1;
      if (cntNext == lateThrQ)  lateQ  <= 1'b1;
    end
  end

  assign earlyRdEn = earlyQ;
  assign lateRdEn  = lateQ;

  // R5: the early group is never behind the late group
  a_r5_early_first: assert property (@(posedge clk) disable iff (!rst_n)
    lateRdEn |-> earlyRdEn);

  // R5: an enable only drops on a pulse
  a_r5_late_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lateRdEn && !ctrl.restart) |=> lateRdEn);

  // R6: a pulse clears both enables
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.restart |=> (!lateRdEn && !earlyRdEn));

  // R3: the late enable rises with the count at its threshold
  a_r3_rise_at_thr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lateRdEn) |-> (cntQ == lateThrQ));

  // R8: the count never passes the late threshold
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= lateThrQ);

endmodule

// File: rtl/align_rd_timer.sv
module align_rd_timer
  import align_timer_pkg::*;
#(
  parameter int BASE    = 96,
  parameter int REG_W   = 16,
  parameter int DLY_W   = 7,
  parameter int OFF_W   = 4,
  parameter int OFF_LSB = 8,
  parameter int DLY_RST = 112,
  parameter int OFF_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l1Reset,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             earlyRdEn,
  output logic             lateRdEn
);

  localparam int CNT_W = $clog2(BASE + (1 << DLY_W));

  logic [DLY_W-1:0] dlyVal;
  logic [OFF_W-1:0] offVal;
  tmrCtrl_t         ctrl;

  align_cfg_reg #(
    .REG_W(REG_W), .DLY_W(DLY_W), .OFF_W(OFF_W), .OFF_LSB(OFF_LSB),
    .DLY_RST(DLY_RST), .OFF_RST(OFF_RST)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .dlyVal(dlyVal), .offVal(offVal)
  );

  align_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .l1Reset(l1Reset), .lateHit(lateRdEn),
    .ctrl(ctrl)
  );

  align_dp #(
    .BASE(BASE), .DLY_W(DLY_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .dlyVal(dlyVal), .offVal(offVal),
    .earlyRdEn(earlyRdEn), .lateRdEn(lateRdEn)
  );

endmodule

// File: tb/test_align_rd_timer.sv
`timescale 1ns/1ps
module test_align_rd_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l1Reset = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        earlyRdEn, lateRdEn;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  align_rd_timer i_align_rd_timer (
    .clk(clk), .rst_n(rst_n), .l1Reset(l1Reset), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .earlyRdEn(earlyRdEn), .lateRdEn(lateRdEn)
  );

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int  mD, mOff, mEl, mLate, mEarly;
  bit  mRun;

  always @(posedge clk) begin
    if (!rst_n) begin
      mD = 112; mOff = 0; mRun = 0; mEl = 0; mLate = 0; mEarly = 0;
    end else begin
      if (l1Reset) begin
        mRun = 1; mEl = 0; mLate = 96 + mD; mEarly = mLate - mOff;
      end else if (mRun) begin
        mEl++;
      end
      if (regWrEn) begin
        mD = int'(regWrData[6:0]);
        mOff = int'(regWrData[11:8]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 late model", int'(lateRdEn), int'(mRun && mEl >= mLate));
      check("R4 early model", int'(earlyRdEn), int'(mRun && mEl >= mEarly));
      check("R2 readback model", int'(regRdData), (mOff << 8) | mD);
    end
  end

  task automatic writeReg(input logic [15:0] val);
    regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse();
    l1Reset = 1'b1;
    @(negedge clk);
    l1Reset = 1'b0;
  endtask

  // counts edges after the pulse edge until each enable is seen high
  task automatic measure(input int wrAt, input logic [15:0] wrVal,
                         output int eN, output int lN);
    int n = 0;
    eN = -1; lN = -1;
    while (lN < 0 && n < 400) begin
      if (earlyRdEn && eN < 0) eN = n;
      if (lateRdEn) lN = n;
      if (lN < 0) begin
        if (n == wrAt) begin
          regWrData = wrVal; regWrEn = 1'b1;
        end
        @(negedge clk);
        regWrEn = 1'b0;
        n++;
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    testsFailed++;
    testsRun++;
    $display("[TB] FAIL watchdog actual=timeout expected=done");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int e, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 defaults and idle
    check("R1 reset readback", int'(regRdData), 16'h0070);
    check("R1 late low", int'(lateRdEn), 0);
    repeat (300) @(negedge clk);
    check("R1 still idle", int'(lateRdEn | earlyRdEn), 0);

    // R3 R4 with defaults: 208 crossings
    pulse(); measure(-1, '0, e, l);
    check("R3 default late", l, 208);
    check("R4 default early", e, 208);

    // R2 layout and ignored bits
    writeReg(16'hF0FF);
    check("R2 ignored bits", int'(regRdData), 16'h007F);
    writeReg(16'h0A14);
    check("R2 layout", int'(regRdData), 16'h0A14);

    // R6 pulse clears high enables
    check("R5 held before pulse", int'(lateRdEn & earlyRdEn), 1);
    pulse();
    check("R6 cleared", int'(lateRdEn | earlyRdEn), 0);
    measure(-1, '0, e, l);
    check("R4 early D20 OFF10", e, 106);
    check("R3 late D20 OFF10", l, 116);

    // R6 mid-count restart
    pulse();
    repeat (50) @(negedge clk);
    pulse(); measure(-1, '0, e, l);
    check("R6 restart late", l, 116);
    check("R6 restart early", e, 106);

    // R7 write during count ignored until next pulse
    pulse(); measure(30, 16'h0000, e, l);
    check("R7 midcount late", l, 116);
    pulse(); measure(-1, '0, e, l);
    check("R7 next pulse late", l, 96);

    // R7 write coincident with pulse
    regWrData = 16'h001E; regWrEn = 1'b1; l1Reset = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; l1Reset = 1'b0;
    measure(-1, '0, e, l);
    check("R7 coincident old value", l, 96);
    pulse(); measure(-1, '0, e, l);
    check("R7 coincident next", l, 126);

    // R8 no wrap
    repeat (400) @(negedge clk);
    check("R8 late still high", int'(lateRdEn), 1);
    check("R8 early still high", int'(earlyRdEn), 1);

    // boundaries
    writeReg(16'h0F00);
    pulse(); measure(-1, '0, e, l);
    check("R4 min early", e, 81);
    check("R3 min late", l, 96);
    writeReg(16'h0F7F);
    pulse(); measure(-1, '0, e, l);
    check("R4 max early", e, 208);
    check("R3 max late", l, 223);
    check("R5 early with late", int'(earlyRdEn), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule